// File: doc/BRIEF.md
# Transmit Jabber Guard

This block sits between the MAC and the line side of a PHY transmit path. It registers the MAC's transmit enable, 4-bit data nibble and error flag onto the line-side outputs with one clock of latency. It also counts how many consecutive clock cycles the transmit enable has been held high. A transmitter that holds enable past the configured limit is treated as runaway, and the block enters a jabber state. In that state it drives the line-side enable, data and error to zero, so the transmission on the line stops.

The jabber state lasts until the MAC drops its enable. No timer or other event ends it while enable stays high. A sticky status bit, read through a management read strobe, records that jabber happened. The limit is a parameter counted in transmit-clock cycles. The default of 1,000,000 cycles is 40 ms at 25 MHz, which meets a cutoff bound of 45 ms.

Top module: `jabber_guard`

## Requirements
- R1: While reset is high and after it is released, lineTxEn, lineTxd and lineTxEr are 0 and jabberStatus is 0.
- R2: Outside jabber, each input sample of macTxEn, macTxd and macTxEr appears unchanged on lineTxEn, lineTxd and lineTxEr one clock after it is sampled.
- R3: A burst of up to TIMEOUT_CYCLES consecutive high macTxEn samples is never gated, and it does not set jabberStatus.
- R4: In a burst, sample number TIMEOUT_CYCLES+1 and every later high sample are forced to lineTxEn=0, lineTxd=0 and lineTxEr=0, starting one clock after that sample.
- R5: The first low macTxEn sample ends jabber and restarts the count, so the next frame passes normally.
- R6: jabberStatus goes to 1 on the clock that enters jabber. It stays at 1 until a statusRead pulse is sampled while jabber is not active, and that pulse clears it on that clock.
- R7: A statusRead pulse sampled while jabber is active leaves jabberStatus at 1.
- R8: A single low macTxEn sample between two bursts restarts the count, so two back-to-back bursts of TIMEOUT_CYCLES samples each pass ungated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| macTxEn | input | 1 | MAC transmit enable |
| macTxd | input | 4 | MAC transmit nibble |
| macTxEr | input | 1 | MAC transmit error |
| statusRead | input | 1 | Management read strobe for the status bit |
| lineTxEn | output | 1 | Registered and gated transmit enable toward the line |
| lineTxd | output | 4 | Registered and gated nibble toward the line |
| lineTxEr | output | 1 | Registered and gated error toward the line |
| jabberStatus | output | 1 | Sticky indication that jabber was detected |

## Verification
Assertions check several rules on every clock. They check that a gated sample reaches the outputs as all zeros, that an ungated sample passes through after exactly one clock, and that a low enable always clears jabber and the count. They also check that jabber never ends while enable stays high, and that the status bit cannot clear while jabber is active. Some properties depend on how long a run of samples is, and only the bench scenarios can show them. These are that exactly TIMEOUT_CYCLES samples pass before gating starts, that a one-cycle gap restarts the count, and that the status bit clears only on a later read.

// File: rtl/jabber_pkg.sv
package jabber_pkg;
  // Strobes from control to datapath for the current input sample
  typedef struct packed {
    logic gate;   // force the registered outputs to idle
    logic enter;  // this sample starts the jabber state
  } jab_ctrl_t;
endpackage

// File: rtl/jabber_ctrl.sv
module jabber_ctrl
  import jabber_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      txEn,
  input  logic      statusRead,
  output jab_ctrl_t ctrl,
  output logic      jabberStatus
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] runCnt;
  logic             jabberQ;
  logic             statusQ;
  logic             atLimit;

  assign atLimit    = (runCnt == LIMIT);
  assign ctrl.enter = txEn && atLimit && !jabberQ;
  assign ctrl.gate  = txEn && (jabberQ || atLimit);

  // Run-length counter of consecutive high enable samples, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (!txEn) begin
      runCnt <= '0;
    end else if (!atLimit) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // Jabber state: set on the over-limit sample, cleared by a low enable
  always_ff @(posedge clk) begin
    if (rst) begin
      jabberQ <= 1'b0;
    end else if (!txEn) begin
      jabberQ <= 1'b0;
    end else if (ctrl.enter) begin
      jabberQ <= 1'b1;
    end
  end

  // Sticky status bit with clear-on-read
  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= 1'b0;
    end else if (ctrl.enter || jabberQ) begin
      statusQ <= 1'b1;
    end else if (statusRead) begin
      statusQ <= 1'b0;
    end
  end

  assign jabberStatus = statusQ;

  // R5: a low enable clears jabber and the count
  a_r5_release_on_low: assert property (@(posedge clk) disable iff (rst)
    !txEn |=> (!jabberQ && runCnt == '0));

  // R4: jabber persists while the enable stays high
  a_r4_jabber_holds: assert property (@(posedge clk) disable iff (rst)
    (jabberQ && txEn) |=> jabberQ);

  // R6: status reflects any active jabber
  a_r6_status_set: assert property (@(posedge clk) disable iff (rst)
    jabberQ |-> statusQ);

  // R7: a read during jabber does not clear the status
  a_r7_read_in_jabber: assert property (@(posedge clk) disable iff (rst)
    (jabberQ && statusRead) |=> statusQ);
endmodule

// File: rtl/jabber_dpath.sv
module jabber_dpath
  import jabber_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  jab_ctrl_t         ctrl,
  input  logic              txEn,
  input  logic [DATA_W-1:0] txd,
  input  logic              txEr,
  output logic              lineTxEn,
  output logic [DATA_W-1:0] lineTxd,
  output logic              lineTxEr
);
  logic              enQ;
  logic [DATA_W-1:0] dQ;
  logic              erQ;

  always_ff @(posedge clk) begin
    if (rst || ctrl.gate) begin
      enQ <= 1'b0;
      dQ  <= '0;
      erQ <= 1'b0;
    end else begin
      enQ <= txEn;
      dQ  <= txd;
      erQ <= txEr;
    end
  end

  assign lineTxEn = enQ;
  assign lineTxd  = dQ;
  assign lineTxEr = erQ;

  // R4: a gated sample reaches the line as idle
  a_r4_gated_idle: assert property (@(posedge clk) disable iff (rst)
    ctrl.gate |=> (!lineTxEn && lineTxd == '0 && !lineTxEr));

  // R2: an ungated sample passes with one clock of latency
  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    !ctrl.gate |=> (lineTxEn == $past(txEn) && lineTxd == $past(txd)
                    && lineTxEr == $past(txEr)));
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jabber_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int DATA_W         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              macTxEn,
  input  logic [DATA_W-1:0] macTxd,
  input  logic              macTxEr,
  input  logic              statusRead,
  output logic              lineTxEn,
  output logic [DATA_W-1:0] lineTxd,
  output logic              lineTxEr,
  output logic              jabberStatus
);
  jab_ctrl_t ctrl;

  jabber_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .txEn(macTxEn), .statusRead(statusRead),
    .ctrl(ctrl), .jabberStatus(jabberStatus)
  );

  jabber_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .txEn(macTxEn), .txd(macTxd),
    .txEr(macTxEr), .lineTxEn(lineTxEn), .lineTxd(lineTxd),
    .lineTxEr(lineTxEr)
  );

  // R1: idle outputs right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!lineTxEn && lineTxd == '0 && !lineTxEr && !jabberStatus));
endmodule

// File: tb/jabber_guard_tb_top.sv
module jabber_guard_tb_top;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic macTxEn = 1'b0;
  logic [3:0] macTxd = '0;
  logic macTxEr = 1'b0;
  logic statusRead = 1'b0;
  logic lineTxEn;
  logic [3:0] lineTxd;
  logic lineTxEr;
  logic jabberStatus;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  jabber_guard #(.TIMEOUT_CYCLES(TO), .DATA_W(4)) dut_i (
    .clk(clk), .rst(rst), .macTxEn(macTxEn), .macTxd(macTxd),
    .macTxEr(macTxEr), .statusRead(statusRead), .lineTxEn(lineTxEn),
    .lineTxd(lineTxd), .lineTxEr(lineTxEr), .jabberStatus(jabberStatus)
  );

  // Pass-through vectors for R2: {en, txd[3:0], er}
  localparam logic [5:0] VEC [8] = '{
    6'b1_0001_0, 6'b1_1010_1, 6'b0_1111_0, 6'b1_0101_0,
    6'b0_0000_1, 6'b1_1111_1, 6'b1_0110_0, 6'b0_1001_0
  };

  task automatic check(input string req, input logic [6:0] act,
                       input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {en,txd,er,stat}=%b expected %b", req, act, exp);
    end
  endtask

  // Drive one sample at the falling edge, check one step after the rising edge
  task automatic step(input logic en, input logic [3:0] d, input logic er,
                      input logic rd, input logic [6:0] exp, input string req);
    @(negedge clk);
    macTxEn = en; macTxd = d; macTxEr = er; statusRead = rd;
    @(posedge clk);
    #1;
    check(req, {lineTxEn, lineTxd, lineTxEr, jabberStatus}, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {lineTxEn, lineTxd, lineTxEr, jabberStatus}, 7'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1", {lineTxEn, lineTxd, lineTxEr, jabberStatus}, 7'b0);

    // R2: table walk
    foreach (VEC[i]) step(VEC[i][5], VEC[i][4:1], VEC[i][0], 1'b0, {VEC[i], 1'b0}, "R2");
    step(1'b0, 4'h0, 1'b0, 1'b0, 7'b0, "R2");

    // R3: burst of exactly TO samples passes
    for (int i = 0; i < TO; i++) step(1'b1, 4'(i + 3), 1'b0, 1'b0, {1'b1, 4'(i + 3), 2'b00}, "R3");
    step(1'b0, 4'h0, 1'b0, 1'b0, 7'b0, "R3");

    // R8: two bursts of TO samples split by one low sample
    for (int i = 0; i < TO; i++) step(1'b1, 4'hA, 1'b1, 1'b0, 7'b1_1010_1_0, "R8");
    step(1'b0, 4'h2, 1'b0, 1'b0, 7'b0_0010_0_0, "R8");
    for (int i = 0; i < TO; i++) step(1'b1, 4'h5, 1'b0, 1'b0, 7'b1_0101_0_0, "R8");
    step(1'b0, 4'h0, 1'b0, 1'b0, 7'b0, "R8");

    // R4: overlong burst; samples after TO are gated, status sets at entry (R6)
    for (int i = 0; i < TO; i++) step(1'b1, 4'hC, 1'b1, 1'b0, 7'b1_1100_1_0, "R4");
    step(1'b1, 4'hC, 1'b1, 1'b0, 7'b0_0000_0_1, "R4/R6");
    step(1'b1, 4'hF, 1'b1, 1'b0, 7'b0_0000_0_1, "R4");
    // R7: read while jabber is active keeps the status set
    step(1'b1, 4'hF, 1'b0, 1'b1, 7'b0_0000_0_1, "R7");
    step(1'b1, 4'h7, 1'b1, 1'b0, 7'b0_0000_0_1, "R4");
    // R5: low enable releases; data with enable low passes again
    step(1'b0, 4'h5, 1'b0, 1'b0, 7'b0_0101_0_1, "R5");
    step(1'b0, 4'h0, 1'b0, 1'b0, 7'b0_0000_0_1, "R6");
    // R6: read when jabber is inactive clears
    step(1'b0, 4'h0, 1'b0, 1'b1, 7'b0_0000_0_0, "R6");
    // R5: next frame is clean
    for (int i = 0; i < TO; i++) step(1'b1, 4'(i), 1'b0, 1'b0, {1'b1, 4'(i), 2'b00}, "R5");
    step(1'b0, 4'h0, 1'b0, 1'b0, 7'b0, "R5");

    // R1: reset in mid-burst returns to idle
    step(1'b1, 4'h9, 1'b1, 1'b0, 7'b1_1001_1_0, "R2");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {lineTxEn, lineTxd, lineTxEr, jabberStatus}, 7'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule